// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block registers eight interrupt request lines and decides which of them, if any, goes to the processor. A per-line trigger-mode input selects how each line is captured. A level-sensitive line's request bit follows the line. An edge-sensitive line's request bit is set by a rising transition and stays set. A falling input does not clear it.

Captured requests are filtered by a mask and scanned in a circular order that starts at a programmable base line. The winner is compared with the most urgent in-service line, scanned in the same circular order, and is reported only when it ranks strictly higher. A nested-mode flag can remove the cascade line's in-service bit from that comparison, so that a further request arriving through the cascade can still win.

The winning line number and its valid flag are combinational from the captured requests and the current control inputs. The interrupt output is the valid flag delayed by one register.

Top module: `irq_resolver`

## Requirements
- R1: On a line whose `trig_level` bit is 1, the captured request bit takes the value of `req_in` at each rising clock edge, whether that value is high or low.
- R2: On a line whose `trig_level` bit is 0, the captured request bit is set at the clock edge where `req_in` is high and was low at the previous edge. The block stores the previous level for this purpose.
- R3: On a line whose `trig_level` bit is 0, a low `req_in` never clears a set request bit. It clears only the stored previous level.
- R4: A line whose `mask` bit is 1 is never reported as the winner.
- R5: Rank is the circular distance (line − `rot_base`) mod 8, where 0 is the most urgent. Among unmasked requests, `win_line` is the line with the smallest rank.
- R6: `win_valid` is 1 only when the winner's rank is strictly smaller than the smallest rank among the set `in_service` bits. An in-service line of equal rank blocks the winner.
- R7: When `nested_en` is 1, the `in_service` bit of line 2 (the cascade line) is left out of the in-service rank. When `nested_en` is 0, that bit counts like any other.
- R8: `irq_out` at each clock edge takes the value `win_valid` had just before that edge.
- R9: While `rst_n` is low at a clock edge, the captured requests, the stored previous levels and `irq_out` clear to 0.
- R10: With no unmasked request, `win_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line trigger mode: 1 selects level, 0 selects edge |
| mask | input | 8 | Per-line mask: 1 blocks the line |
| in_service | input | 8 | Lines currently being serviced |
| rot_base | input | 3 | Line that holds the most urgent rank |
| nested_en | input | 1 | Leave the cascade line out of the in-service comparison |
| win_line | output | 3 | Winning line number; meaningful when win_valid is 1 |
| win_valid | output | 1 | A request outranks everything in service |
| irq_out | output | 1 | Registered interrupt to the processor |

## Verification
A wrong stored request or previous-level bit is visible at the ports in the cycle after the capturing edge. It shows up as a line that stays reported after an edge-mode fall, a line that never appears, or a repeated edge that fires again. A fault in the rotation or in-service scan shows as a wrong `win_line` or `win_valid` in the same cycle as the input change. The bench therefore compares both outputs after every edge and compares `irq_out` one edge later. It steps `rot_base` through every value and covers equal-rank in-service lines and the nested-mode exception.

// File: rtl/irq_resolver_pkg.sv
// Shared defaults for the interrupt request resolver.
package irq_resolver_pkg;
    localparam int unsigned DEF_LINES   = 8;  // request lines, a power of two
    localparam int unsigned DEF_CASCADE = 2;  // line fed by a downstream resolver
endpackage

// File: rtl/irq_capture.sv
// Request capture: one register per line. In level mode the bit follows the
// input. In edge mode a rising transition (seen against the stored previous
// level) sets the bit, and nothing here clears it.
// Assumes req_in is already synchronous to clk.
module irq_capture #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] trig_level,
    output logic [N-1:0] req_q
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        // Track the previous level and update the request bit of one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g]  <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= req_in[g];
                if (trig_level[g])
                    req_q[g] <= req_in[g];
                else if (req_in[g] && !prev_q[g])
                    req_q[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_prio_scan.sv
// Rotating priority scan: returns the smallest offset k for which
// vec[(k + base) mod N] is set. Returns N when vec is empty.
// Assumes N is a power of two so the index wraps naturally.
module irq_prio_scan #(
    parameter int unsigned N      = 8,
    localparam int unsigned IDX_W  = $clog2(N),
    localparam int unsigned PRIO_W = IDX_W + 1
) (
    input  logic [N-1:0]      vec,
    input  logic [IDX_W-1:0]  base,
    output logic [PRIO_W-1:0] prio
);
    // Walk offsets from least to most urgent so the most urgent hit is kept last.
    always_comb begin
        prio = PRIO_W'(N);
        for (int off = N - 1; off >= 0; off--) begin
            if (vec[IDX_W'(IDX_W'(off) + base)])
                prio = PRIO_W'(off);
        end
    end
endmodule

// File: rtl/irq_resolver.sv
// Top level: capture, masking, two rotating scans (pending and in-service),
// strict comparison and a registered interrupt output.
// Assumes the caller keeps in_service, mask and rot_base consistent with
// its own acknowledge and end-of-service sequencing.
module irq_resolver
    import irq_resolver_pkg::*;
#(
    parameter int unsigned N       = DEF_LINES,
    parameter int unsigned CASCADE = DEF_CASCADE,
    localparam int unsigned IDX_W  = $clog2(N),
    localparam int unsigned PRIO_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_in,
    input  logic [N-1:0]     trig_level,
    input  logic [N-1:0]     mask,
    input  logic [N-1:0]     in_service,
    input  logic [IDX_W-1:0] rot_base,
    input  logic             nested_en,
    output logic [IDX_W-1:0] win_line,
    output logic             win_valid,
    output logic             irq_out
);
    logic [N-1:0]      req_q;
    logic [N-1:0]      pending;
    logic [N-1:0]      isr_eff;
    logic [PRIO_W-1:0] pend_prio;
    logic [PRIO_W-1:0] isr_prio;

    irq_capture #(.N(N)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (req_in),
        .trig_level (trig_level),
        .req_q      (req_q)
    );

    // Drop masked lines and, in nested mode, the cascade in-service bit.
    always_comb begin
        pending = req_q & ~mask;
        isr_eff = in_service;
        if (nested_en)
            isr_eff[CASCADE] = 1'b0;
    end

    irq_prio_scan #(.N(N)) u_pend_scan (
        .vec  (pending),
        .base (rot_base),
        .prio (pend_prio)
    );

    irq_prio_scan #(.N(N)) u_isr_scan (
        .vec  (isr_eff),
        .base (rot_base),
        .prio (isr_prio)
    );

    // Report the winner only when it strictly outranks the in-service level.
    always_comb begin
        win_valid = pend_prio < isr_prio;
        win_line  = IDX_W'(pend_prio[IDX_W-1:0] + rot_base);
    end

    // Register the interrupt request toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= 1'b0;
        else
            irq_out <= win_valid;
    end
endmodule

// File: rtl/irq_resolver_chk.sv
// Property checker for irq_resolver, attached through bind.
module irq_resolver_chk #(
    parameter int unsigned N       = 8,
    parameter int unsigned CASCADE = 2,
    localparam int unsigned IDX_W  = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req_in,
    input logic [N-1:0]     trig_level,
    input logic [N-1:0]     mask,
    input logic [N-1:0]     in_service,
    input logic             nested_en,
    input logic [N-1:0]     req_q,
    input logic [IDX_W-1:0] win_line,
    input logic             win_valid,
    input logic             irq_out
);
    // R1
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_q & $past(trig_level)) == $past(req_in & trig_level));

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_q & $past(req_q & ~trig_level)) == $past(req_q & ~trig_level));

    // R4
    masked_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !mask[win_line]);

    // R6
    outrank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !(nested_en && win_line == IDX_W'(CASCADE))) |-> !in_service[win_line]);

    // R8
    irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == $past(win_valid));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & ~mask) == '0) |-> !win_valid);
endmodule

bind irq_resolver irq_resolver_chk #(.N(N), .CASCADE(CASCADE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in     (req_in),
    .trig_level (trig_level),
    .mask       (mask),
    .in_service (in_service),
    .nested_en  (nested_en),
    .req_q      (req_q),
    .win_line   (win_line),
    .win_valid  (win_valid),
    .irq_out    (irq_out)
);

// File: tb/irq_resolver_tb.sv
module irq_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_in, trig_level, mask, in_service;
    logic [2:0] rot_base;
    logic       nested_en;
    logic [2:0] win_line;
    logic       win_valid, irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] m_req, m_prev;

    always #4 clk = ~clk;  // 125 MHz

    irq_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
        .mask(mask), .in_service(in_service), .rot_base(rot_base),
        .nested_en(nested_en), .win_line(win_line), .win_valid(win_valid),
        .irq_out(irq_out)
    );

    // Rank of the most urgent set bit, 8 when empty.
    function automatic int rank_of(input logic [7:0] v, input logic [2:0] b);
        for (int k = 0; k < 8; k++)
            if (v[3'(3'(k) + b)]) return k;
        return 8;
    endfunction

    // Expected {valid, line} for a given captured request vector.
    function automatic logic [3:0] expect_win(input logic [7:0] rq);
        logic [7:0] isr;
        int pr, ir;
        isr = in_service;
        if (nested_en) isr[2] = 1'b0;
        pr = rank_of(rq & ~mask, rot_base);
        ir = rank_of(isr, rot_base);
        return {pr < ir, 3'(3'(pr) + rot_base)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge capture, check at the next fall.
    task automatic step(input string tag, input logic [7:0] r, input logic [7:0] t,
                        input logic [7:0] m, input logic [7:0] s,
                        input logic [2:0] b, input logic n);
        logic pre;
        logic [3:0] e;
        req_in = r; trig_level = t; mask = m; in_service = s; rot_base = b; nested_en = n;
        #1;
        pre = expect_win(m_req)[3];
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            if (t[i]) m_req[i] = r[i];
            else if (r[i] && !m_prev[i]) m_req[i] = 1'b1;
        end
        m_prev = r;
        @(negedge clk);
        e = expect_win(m_req);
        check({tag, " R2 R3 R5 R6 valid"}, 32'(win_valid), 32'(e[3]));
        if (e[3]) check({tag, " R1 R4 R5 R7 line"}, 32'(win_line), 32'(e[2:0]));
        check({tag, " R8 irq_out"}, 32'(irq_out), 32'(pre));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unsigned seed = 32'd7;
        void'($urandom(seed));
        rst_n = 1'b0;
        req_in = 8'hFF; trig_level = 8'hFF; mask = 0; in_service = 0; rot_base = 0; nested_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9 irq_out in reset", 32'(irq_out), 0);
        check("R9 win_valid in reset", 32'(win_valid), 0);
        req_in = 0;
        rst_n = 1'b1;
        m_req = 0; m_prev = 0;
        @(negedge clk);
        check("R9 R10 idle after reset", 32'(win_valid), 0);

        // R2 edge rise on line 5, then R3 fall keeps it
        step("R2 rise",  8'h20, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0);
        check("R2 line5", 32'(win_line), 32'd5);
        step("R3 fall",  8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0);
        check("R3 held", 32'(win_valid), 1);
        // R1 level mode clears with low input
        step("R1 low",   8'h00, 8'hFF, 8'h00, 8'h00, 3'd0, 1'b0);
        check("R1 cleared", 32'(win_valid), 0);
        // R5 rotation: lines 0 and 7 requested, base 1 picks 7
        step("R5 rot",   8'h81, 8'hFF, 8'h00, 8'h00, 3'd1, 1'b0);
        check("R5 line7", 32'(win_line), 32'd7);
        // R4 mask hides line 7
        step("R4 mask",  8'h81, 8'hFF, 8'h80, 8'h00, 3'd1, 1'b0);
        check("R4 line0", 32'(win_line), 32'd0);
        // R6 equal rank in service blocks
        step("R6 equal", 8'h08, 8'hFF, 8'h00, 8'h08, 3'd0, 1'b0);
        check("R6 blocked", 32'(win_valid), 0);
        // R7 cascade line in service
        step("R7 off",   8'h04, 8'hFF, 8'h00, 8'h04, 3'd0, 1'b0);
        check("R7 off blocked", 32'(win_valid), 0);
        step("R7 on",    8'h04, 8'hFF, 8'h00, 8'h04, 3'd0, 1'b1);
        check("R7 on wins", 32'(win_valid), 1);
        // every base value with all lines requested
        for (int b = 0; b < 8; b++) begin
            step("R5 sweep", 8'hFF, 8'hFF, 8'h00, 8'h00, 3'(b), 1'b0);
            check("R5 sweep line", 32'(win_line), 32'(b));
        end
        // random mix
        for (int i = 0; i < 2000; i++)
            step("rand", 8'($urandom), 8'($urandom), 8'($urandom) & 8'($urandom),
                 8'($urandom) & 8'($urandom) & 8'($urandom), 3'($urandom), 1'($urandom));
        finish_run();
    end
endmodule